// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial-bus protocol engine of a small byte-wide nonvolatile store. The engine hands it a word address at the start of a write transaction and then one strobe per received data byte. Each byte goes into an 8-slot page latch, and a flag marks that slot as loaded. Only the low in-page bits of the shared address pointer advance, so a long burst wraps round inside one page and overwrites bytes it loaded earlier.

When the engine reports a Stop, the block commits the loaded slots of that page to a 256x8 array model. It walks the slots in ascending order, drives the array write port once for each loaded slot, and holds `busy_o` high for a programmable number of clock cycles. While busy, every strobe is dropped. A write-protect pin vetoes the whole commit, and reads are always allowed when the block is idle. The protocol engine reads through the same pointer, which advances across the whole array. A transaction that is abandoned without a Stop is discarded, but the address it loaded still sets the pointer, which is how a random read is set up.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are low, `rd_data_o` is 0, the pointer is 0 and every array location reads 0.
- R2: A data byte accepted with pointer P is stored in the slot given by P[2:0]. The pointer then becomes {P[7:3], P[2:0]+1 mod 8}, so its upper bits never change on a data byte.
- R3: When a transaction carries more than 8 data bytes, the last byte sent to a slot is the one that reaches the array.
- R4: A Stop starts a write cycle only when at least one data byte was accepted since the last address load. A Stop with no bytes leaves `busy_o` low.
- R5: A commit writes only the loaded slots. All other locations of the page keep their old contents.
- R6: With `wp_i` high, no array location changes. A Stop with loaded bytes discards them without raising `busy_o`, and a later Stop with `wp_i` low commits nothing.
- R7: `busy_o` rises in the cycle after an accepted Stop and stays high for exactly WRITE_CYCLES cycles.
- R8: While `busy_o` is high, the address-load, byte, Stop and read strobes are all ignored. The pointer, the latch and `rd_data_o` stay as they are.
- R9: After a commit, the pointer equals the in-page address after the last byte written plus one, wrapped within the page.
- R10: A read strobe makes `rd_data_o` show the array byte at the pointer one cycle later. The pointer then advances by one over the full array, so 255 is followed by 0.
- R11: An address load or a read that arrives while bytes are loaded discards those bytes. A following Stop then starts no write cycle.
- R12: An address load with no data bytes after it (a dummy write) sets the pointer for the next read.
- R13: During a commit, `mem_we_o` pulses exactly once for each loaded slot, in the busy cycle whose index equals the slot number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_addr_i | input | 1 | Load `addr_i` into the pointer; starts a transaction |
| addr_i | input | ADDR_W | Word address from the protocol engine |
| byte_vld_i | input | 1 | A received data byte is present |
| byte_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Stop seen on the bus |
| rd_en_i | input | 1 | Read one byte at the pointer |
| wp_i | input | 1 | Write protect; high blocks every array write |
| busy_o | output | 1 | Self-timed write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| rd_data_o | output | DATA_W | Byte returned by the last accepted read |

## Verification
A wrong slot index or valid flag shows up as a wrong byte when the page is read back as soon as `busy_o` falls. A missing or extra write shows up earlier, as a wrong count of `mem_we_o` pulses within the first eight busy cycles. A pointer that is wrong after a commit is caught by the very first read that follows. A timer error changes the length of `busy_o`, which is measured to the exact cycle. The sweep covers every start slot and burst lengths from 1 to 10 on several pages, so wrap-round and partial pages are checked against an arithmetic model.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } pwb_seq_e;

   function automatic int pwb_page_bytes(input int page_w);
      return 1 << page_w;
   endfunction

endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [PAGE_W-1:0] wr_slot_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              clear_i,
   input  logic [PAGE_W-1:0] rd_slot_i,
   output logic              any_valid_o,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int SLOTS = pwb_pkg::pwb_page_bytes(PAGE_W);

   logic [SLOTS-1:0]  valid_q;
   logic [DATA_W-1:0] data_q [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[k] <= 1'b0;
            data_q[k]  <= '0;
         end else if (clear_i) begin
            valid_q[k] <= 1'b0;
         end else if (wr_i && (wr_slot_i == PAGE_W'(k))) begin
            valid_q[k] <= 1'b1;
            data_q[k]  <= wr_data_i;
         end
      end
   end

   assign any_valid_o = |valid_q;
   assign rd_valid_o  = valid_q[rd_slot_i];
   assign rd_data_o   = data_q[rd_slot_i];

   // R11: a clear empties every slot flag
   assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !any_valid_o);

   // R2: a write always leaves at least one loaded slot
   assert_write_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clear_i) |=> any_valid_o);

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer #(
   parameter int PAGE_W       = 3,
   parameter int WRITE_CYCLES = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   output logic              busy_o,
   output logic              walk_o,
   output logic [PAGE_W-1:0] slot_o,
   output logic              done_o
);
   import pwb_pkg::*;

   localparam int SLOTS = pwb_page_bytes(PAGE_W);
   localparam int CYC_W = $clog2(WRITE_CYCLES) + 1;

   pwb_seq_e          state_q;
   logic [CYC_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (go_i) begin
               state_q <= SQ_RUN;
               cnt_q   <= '0;
            end
            SQ_RUN: if (cnt_q == CYC_W'(WRITE_CYCLES - 1)) begin
               state_q <= SQ_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q == SQ_RUN);
   assign walk_o = busy_o && (cnt_q < CYC_W'(SLOTS));
   assign slot_o = cnt_q[PAGE_W-1:0];
   assign done_o = busy_o && (cnt_q == CYC_W'(WRITE_CYCLES - 1));

   // R7: an accepted go always opens a write cycle
   assert_go_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && !busy_o) |=> busy_o);

   // R7: busy holds until the terminal count
   assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // R7: the terminal count ends the cycle
   assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   if (CLEAR_ON_RST) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (we_i) mem_q[waddr_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (re_i) rdata_o <= mem_q[raddr_i];
   end

   // R8: the read port is never serviced during a commit write
   assert_no_read_in_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(re_i && we_i));

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int PAGE_W       = 3,
   parameter int WRITE_CYCLES = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              rd_en_i,
   input  logic              wp_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int SLOTS = pwb_pkg::pwb_page_bytes(PAGE_W);
   localparam int ROW_W = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("page_write_buffer: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (WRITE_CYCLES < SLOTS) begin : g_bad_cycles
      $error("page_write_buffer: WRITE_CYCLES must cover one slot per cycle");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("page_write_buffer: DATA_W must be positive");
   end

   logic              idle;
   logic              acc_ld, acc_byte, acc_stop, acc_rd;
   logic [ADDR_W-1:0] ptr_q;
   logic              any_valid, slot_valid;
   logic [DATA_W-1:0] slot_data;
   logic              walk, done, go, clear;
   logic [PAGE_W-1:0] walk_slot;

   // one strobe per cycle is honoured: load, byte, stop, read in that order
   assign idle     = !busy_o;
   assign acc_ld   = idle && ld_addr_i;
   assign acc_byte = idle && !ld_addr_i && byte_vld_i;
   assign acc_stop = idle && !ld_addr_i && !byte_vld_i && stop_i;
   assign acc_rd   = idle && !ld_addr_i && !byte_vld_i && !stop_i && rd_en_i;

   assign go    = acc_stop && any_valid && !wp_i;
   assign clear = acc_ld || acc_rd || (acc_stop && wp_i) || done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (acc_ld) begin
         ptr_q <= addr_i;
      end else if (acc_byte) begin
         ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
      end else if (acc_rd) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   pwb_latch #(
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (acc_byte),
      .wr_slot_i   (ptr_q[PAGE_W-1:0]),
      .wr_data_i   (byte_i),
      .clear_i     (clear),
      .rd_slot_i   (walk_slot),
      .any_valid_o (any_valid),
      .rd_valid_o  (slot_valid),
      .rd_data_o   (slot_data)
   );

   pwb_sequencer #(
      .PAGE_W       (PAGE_W),
      .WRITE_CYCLES (WRITE_CYCLES)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go),
      .busy_o (busy_o),
      .walk_o (walk),
      .slot_o (walk_slot),
      .done_o (done)
   );

   assign mem_we_o    = walk && slot_valid && !wp_i;
   assign mem_addr_o  = {ptr_q[ADDR_W-1:PAGE_W], walk_slot};
   assign mem_wdata_o = slot_data;

   pwb_array #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .CLEAR_ON_RST (1'b1)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we_o),
      .waddr_i (mem_addr_o),
      .wdata_i (mem_wdata_o),
      .re_i    (acc_rd),
      .raddr_i (ptr_q),
      .rdata_o (rd_data_o)
   );

   // R4: busy only ever follows a Stop strobe
   assert_busy_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));

   // R6: no array write while protected, none outside a cycle
   assert_we_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (busy_o && !wp_i));

   // R6: a protected Stop never opens a cycle
   assert_wp_no_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && wp_i && !busy_o) |=> !busy_o);

   // R8: pointer frozen while busy
   assert_ptr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(ptr_q));

   // R2: a data byte never moves the pointer off its page
   assert_row_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_byte |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

   // R7: every loaded slot is consumed by the end of a cycle
   assert_latch_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !any_valid);

   logic [ROW_W-1:0] unused_row;
   assign unused_row = ptr_q[ADDR_W-1:PAGE_W];

endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
   localparam int WC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_addr_i = 1'b0;
   logic [7:0] addr_i = '0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       stop_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic       wp_i = 1'b0;
   logic       busy_o, mem_we_o;
   logic [7:0] mem_addr_o, mem_wdata_o, rd_data_o;

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   bit done_flag = 1'b0;

   logic [7:0] ref_mem [256];
   logic [7:0] ref_slot [8];
   bit         ref_v [8];
   logic [7:0] ref_ptr;

   always #5 clk = ~clk;

   page_write_buffer #(
      .ADDR_W(8), .DATA_W(8), .PAGE_W(3), .WRITE_CYCLES(WC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ld_addr_i(ld_addr_i), .addr_i(addr_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
      .rd_en_i(rd_en_i), .wp_i(wp_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .rd_data_o(rd_data_o)
   );

   always @(negedge clk) if (mem_we_o) we_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic discard();
      for (int k = 0; k < 8; k++) ref_v[k] = 1'b0;
   endtask

   task automatic do_ld(input logic [7:0] a);
      ld_addr_i = 1'b1; addr_i = a;
      @(negedge clk);
      ld_addr_i = 1'b0;
      if (!busy_o) begin ref_ptr = a; discard(); end
   endtask

   task automatic do_byte(input logic [7:0] d);
      byte_vld_i = 1'b1; byte_i = d;
      @(negedge clk);
      byte_vld_i = 1'b0;
      ref_slot[ref_ptr[2:0]] = d;
      ref_v[ref_ptr[2:0]] = 1'b1;
      ref_ptr = {ref_ptr[7:3], ref_ptr[2:0] + 3'd1};
   endtask

   // returns the number of busy cycles seen
   task automatic do_stop(output int bcyc, output int pulses);
      int any = 0;
      int w0;
      for (int k = 0; k < 8; k++) if (ref_v[k]) any++;
      w0 = we_cnt;
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      bcyc = 0;
      while (busy_o && bcyc < 4 * WC) begin
         bcyc++;
         @(negedge clk);
      end
      pulses = we_cnt - w0;
      if (any > 0 && !wp_i)
         for (int k = 0; k < 8; k++)
            if (ref_v[k]) ref_mem[{ref_ptr[7:3], 3'(k)}] = ref_slot[k];
      discard();
   endtask

   task automatic do_rd(input string req);
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      chk(req, rd_data_o, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
      discard();
   endtask

   initial begin
      #(200000 * 10);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int bc, pc, nv;
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
      discard();
      ref_ptr = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 busy", busy_o, 0);
      chk("R1 we", mem_we_o, 0);
      chk("R1 rd_data", rd_data_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_rd("R1 pointer zero, array zero");
      do_ld(8'h9C);
      do_rd("R1 array location zero");

      // R2 R3 R5 R9 R13 sweep: pages, start slots, burst lengths
      for (int pg = 0; pg < 3; pg++) begin
         for (int s = 0; s < 8; s++) begin
            for (int n = 1; n <= 10; n++) begin
               logic [7:0] base;
               base = (pg == 0) ? 8'h00 : (pg == 1) ? 8'h28 : 8'hF8;
               do_ld(base | 8'(s));
               for (int i = 0; i < n; i++)
                  do_byte(8'((pg * 61 + s * 17 + n * 29 + i * 7 + 3) & 8'hFF));
               nv = (n > 8) ? 8 : n;
               do_stop(bc, pc);
               chk("R7 busy length", bc, WC);
               chk("R13 write pulses", pc, nv);
               chk("R9 pointer after commit", ref_ptr, int'({base[7:3], 3'(s + n)}));
               do_rd("R9 first read after commit");
               do_ld(base);
               for (int k = 0; k < 8; k++) do_rd("R2 R3 R5 page readback");
            end
         end
      end

      // R4: Stop without bytes
      do_ld(8'h40);
      do_stop(bc, pc);
      chk("R4 no cycle on empty stop", bc, 0);
      chk("R4 no write pulses", pc, 0);

      // R6: write protect
      wp_i = 1'b1;
      do_ld(8'h50);
      do_byte(8'hA5); do_byte(8'h5A);
      do_stop(bc, pc);
      chk("R6 no cycle when protected", bc, 0);
      chk("R6 no write pulses", pc, 0);
      wp_i = 1'b0;
      do_stop(bc, pc);
      chk("R6 later stop commits nothing", bc, 0);
      do_ld(8'h50);
      do_rd("R6 location 0x50 unchanged");
      do_rd("R6 location 0x51 unchanged");

      // R11: abort by address load, then by read
      do_ld(8'h60);
      do_byte(8'h11);
      do_ld(8'h70);
      do_stop(bc, pc);
      chk("R11 load aborts", bc, 0);
      do_ld(8'h60);
      do_byte(8'h22);
      do_rd("R11 read during pending bytes");
      do_stop(bc, pc);
      chk("R11 read aborts", bc, 0);
      do_ld(8'h60);
      do_rd("R11 location 0x60 unchanged");

      // R8: strobes during busy
      do_ld(8'h30);
      do_byte(8'hC3);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      ref_mem[8'h30] = 8'hC3;
      discard();
      begin
         logic [7:0] held;
         held = rd_data_o;
         rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
         chk("R8 read ignored while busy", rd_data_o, held);
         ld_addr_i = 1'b1; addr_i = 8'h90; @(negedge clk); ld_addr_i = 1'b0;
         byte_vld_i = 1'b1; byte_i = 8'h77; @(negedge clk); byte_vld_i = 1'b0;
         stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
         chk("R8 busy still high", busy_o, 1);
      end
      while (busy_o) @(negedge clk);
      do_stop(bc, pc);
      chk("R8 byte during busy not latched", bc, 0);
      do_rd("R8 pointer unchanged by busy strobes");
      do_ld(8'h90);
      do_rd("R8 0x90 not written");

      // R10 R12: dummy write then read across top of array
      do_ld(8'hFF);
      do_byte(8'hE1);
      do_stop(bc, pc);
      do_ld(8'hFF);
      do_rd("R12 dummy write sets pointer");
      do_rd("R10 wrap from 255 to 0");
      chk("R10 pointer after wrap", ref_ptr, 1);

      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule